// File: doc/BRIEF.md
# Timer-Driven Square-Wave Pin Divider

This block turns a 16-bit up-counting timer into a square-wave source for a single port pin. Software writes a preload value N. While the timer runs, the counter climbs from N to its all-ones value, reloads N on the following clock and toggles an internal wave flip-flop. The flip-flop therefore changes state every 2^W − N timer clocks, so the pin frequency is f_clk / (2 × (2^W − N)).

The pin's own port data bit acts as a gate on the wave. With the bit set, the pad follows the wave flip-flop. With the bit clear, the pad is forced low whatever the timer is doing. The pin's direction bit decides whether the pad driver is enabled at all.

Stopping the timer clears the wave flip-flop, so a stopped timer with the data bit set drives a defined low level. The preload arrives on a valid/ready port. Ready is always high, so a word is taken on every clock in which valid is high and there is no back-pressure. The run, data and direction inputs are plain level controls.

Top module: `freqdiv_pin`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises with run_en low, pad_out is 0 and the wave flip-flop is 0.
- R2: While run_en is high, the pad (with port_bit=1, dir_out=1) changes level once every 2^W − N clocks, giving a full period of 2 × (2^W − N) clocks for preload N.
- R3: A preload of 2^W − 1 makes the pad toggle on every clock, giving a period of 2 clocks.
- R4: A preload written while the timer runs does not disturb the count in progress. It is first used at the next reload after overflow.
- R5: While run_en is low, the counter holds at the latest preload (a word written in the same cycle included) and the wave flip-flop is cleared to 0. The first overflow then comes 2^W − N clocks after run_en rises.
- R6: With port_bit = 0, pad_out is 0 in every timer state.
- R7: With run_en = 1, port_bit = 1 and dir_out = 1, pad_out equals the wave flip-flop on every clock.
- R8: pad_oe equals dir_out. With dir_out = 0, pad_out is 0.
- R9: pre_ready is constantly 1, and a preload beat is accepted on every clock with pre_valid = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Timer run enable |
| pre_valid | input | 1 | Preload word valid |
| pre_data | input | W (16) | Preload value N |
| pre_ready | output | 1 | Preload ready, always 1 |
| port_bit | input | 1 | Pin data latch bit, gates the wave |
| dir_out | input | 1 | Pin direction, 1 = output |
| pad_out | output | 1 | Pad data |
| pad_oe | output | 1 | Pad output enable |

## Verification
The assertions assume that run_en, port_bit, dir_out and the preload beat are stable across each rising edge. They also assume that pre_data has a known value whenever pre_valid is high. The bench meets these assumptions by changing every input only on the falling clock edge, from tasks. A behavioural model steps the count, reload and wave state alongside the design and compares both pad outputs every cycle. Period measurements for several preloads, a preload written mid-count, and the data-bit and direction gating cases are checked separately by edge timing.

// File: rtl/fdo_pkg.sv
package fdo_pkg;
  // Selection made by the pad gate for what the pin shows
  typedef enum logic [1:0] {
    PAD_OFF  = 2'd0,  // driver disabled, data low
    PAD_LOW  = 2'd1,  // data latch cleared, forced low
    PAD_WAVE = 2'd2   // wave flip-flop on the pin
  } pad_sel_e;
endpackage

// File: rtl/fdo_counter.sv
module fdo_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] reload_q;
  logic [W-1:0] reload_nxt;

  assign reload_nxt = wr_valid ? wr_data : reload_q;
  assign wrap       = run && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (wr_valid) begin
      reload_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= reload_nxt;
    end else if (cnt_q == TOP) begin
      cnt_q <= reload_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  reload_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == $past(reload_q)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_valid) |=> (cnt_q == $past(wr_data)));
endmodule

// File: rtl/fdo_toggle.sv
module fdo_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wrap,
  output logic wave
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave <= 1'b0;
    end else if (!run) begin
      wave <= 1'b0;
    end else if (wrap) begin
      wave <= ~wave;
    end
  end

  // R2
  wave_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (wave != $past(wave)));

  // R2
  wave_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(wave));

  // R5
  wave_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wave);
endmodule

// File: rtl/fdo_padgate.sv
module fdo_padgate
  import fdo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_bit,
  input  logic dir_out,
  input  logic wave,
  output logic pad_out,
  output logic pad_oe
);
  pad_sel_e sel;

  always_comb begin
    if (!dir_out)       sel = PAD_OFF;
    else if (!port_bit) sel = PAD_LOW;
    else                sel = PAD_WAVE;
  end

  always_comb begin
    unique case (sel)
      PAD_WAVE: begin pad_out = wave; pad_oe = 1'b1; end
      PAD_LOW:  begin pad_out = 1'b0; pad_oe = 1'b1; end
      default:  begin pad_out = 1'b0; pad_oe = 1'b0; end
    endcase
  end

  // R6
  data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_bit |-> !pad_out);

  // R8
  dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_out |-> (!pad_oe && !pad_out));
endmodule

// File: rtl/freqdiv_pin.sv
module freqdiv_pin #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         pre_valid,
  input  logic [W-1:0] pre_data,
  output logic         pre_ready,
  input  logic         port_bit,
  input  logic         dir_out,
  output logic         pad_out,
  output logic         pad_oe
);
  logic wrap;
  logic wave;

  assign pre_ready = 1'b1;

  fdo_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_en),
    .wr_valid(pre_valid && pre_ready), .wr_data(pre_data), .wrap(wrap)
  );

  fdo_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .run(run_en), .wrap(wrap), .wave(wave)
  );

  fdo_padgate u_pad (
    .clk(clk), .rst_n(rst_n), .port_bit(port_bit), .dir_out(dir_out),
    .wave(wave), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // R9
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ready);

  // R7
  wave_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && port_bit && dir_out) |-> (pad_out == wave));
endmodule

// File: tb/sim_freqdiv_pin.sv
`timescale 1ns/1ps
module sim_freqdiv_pin;
  localparam int W = 16;
  localparam int MODV = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic pre_valid = 1'b0;
  logic [W-1:0] pre_data = '0;
  logic pre_ready;
  logic port_bit = 1'b0;
  logic dir_out = 1'b0;
  logic pad_out;
  logic pad_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_cnt = 0;
  int m_rel = 0;
  int m_wave = 0;

  always #4 clk = ~clk;  // 125 MHz

  freqdiv_pin #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_valid(pre_valid),
    .pre_data(pre_data), .pre_ready(pre_ready), .port_bit(port_bit),
    .dir_out(dir_out), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_wave = 0;
    end else begin
      if (!run_en) begin
        m_cnt = pre_valid ? int'(pre_data) : m_rel;
        m_wave = 0;
      end else if (m_cnt == MODV - 1) begin
        m_cnt = m_rel;
        m_wave = 1 - m_wave;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (pre_valid) m_rel = int'(pre_data);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // lockstep comparison every cycle, R7 and R8
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 lockstep pad_out", int'(pad_out),
            (dir_out && port_bit) ? m_wave : 0);
      check("R8 lockstep pad_oe", int'(pad_oe), int'(dir_out));
    end
  end

  task automatic wr_pre(input int n);
    pre_valid = 1'b1; pre_data = W'(n);
    @(negedge clk);
    pre_valid = 1'b0;
  endtask

  // starts the timer from preload n, returns the cycle stamp of the start
  task automatic start_from(input int n, output int t0);
    run_en = 1'b0;
    wr_pre(n);
    @(negedge clk);
    run_en = 1'b1;
    t0 = cyc;
  endtask

  task automatic wait_level(input logic lvl, output int stamp);
    int guard = 0;
    while (pad_out !== lvl && guard < 3 * MODV) begin
      @(negedge clk);
      guard++;
    end
    stamp = cyc;
  endtask

  task automatic measure(input int n, input string req);
    int t0, a, b, c;
    start_from(n, t0);
    wait_level(1'b1, a);
    check({req, " first overflow"}, a - t0, MODV - n);
    wait_level(1'b0, b);
    wait_level(1'b1, c);
    check({req, " full period"}, c - a, 2 * (MODV - n));
    check({req, " half period"}, b - a, MODV - n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, a, b;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 pad_out in reset", int'(pad_out), 0);
    dir_out = 1'b1; port_bit = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pad_out after reset", int'(pad_out), 0);
    check("R9 pre_ready", int'(pre_ready), 1);

    // R2 periods for several preloads
    measure(65500, "R2 N=65500");
    measure(65000, "R2 N=65000");
    measure(65530, "R2 N=65530");
    // R3 every-clock toggling
    measure(65535, "R3 N=65535");

    // R4 preload written mid-count
    start_from(65000, t0);
    repeat (100) @(negedge clk);
    wr_pre(65530);
    wait_level(1'b1, a);
    check("R4 count undisturbed", a - t0, MODV - 65000);
    wait_level(1'b0, b);
    check("R4 new preload at reload", b - a, MODV - 65530);

    // R5 stopping clears the wave and holds pad low
    wait_level(1'b1, a);
    run_en = 1'b0;
    @(negedge clk);
    check("R5 stop clears wave", int'(pad_out), 0);
    repeat (20) @(negedge clk);
    check("R5 stays low when stopped", int'(pad_out), 0);
    // R5 same-cycle write while stopped is the start point
    pre_valid = 1'b1; pre_data = W'(65526);
    @(negedge clk);
    pre_valid = 1'b0; run_en = 1'b1; t0 = cyc;
    wait_level(1'b1, a);
    check("R5 start from latest preload", a - t0, MODV - 65526);

    // R6 data bit cleared while running
    port_bit = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pad_out !== 1'b0) check("R6 data gate", int'(pad_out), 0);
    end
    check("R6 data gate end", int'(pad_out), 0);
    port_bit = 1'b1;

    // R8 input direction disables the driver
    dir_out = 1'b0;
    repeat (15) @(negedge clk);
    check("R8 oe off", int'(pad_oe), 0);
    check("R8 out low", int'(pad_out), 0);
    dir_out = 1'b1;
    @(negedge clk);
    check("R8 oe on", int'(pad_oe), 1);
    check("R9 pre_ready end", int'(pre_ready), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule